// File: doc/BRIEF.md
# Command-Driven Serial Flash Master

This block is the serial-flash side of a small processor core. The core's decoder turns four dedicated instructions into commands on a request/busy/data handshake. Two commands set the flash chip-select level. The other two move a single byte: one sends a byte to the flash and the other receives one.

Chip select is its own commanded level. It is not framed around each byte, so software opens a selection, runs any number of one-byte transfers, and then closes it. The block only shifts bytes. It never builds flash commands itself, so nothing it does on its own can cause a write.

The serial clock follows SPI mode 0 and comes from a programmable divider off the system clock. Each half-period lasts `clk_div + 1` system cycles, and the serial clock rests low whenever no byte is in flight.

Top module: `spi_cmd_port`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0, `cmd_busy` is 0 and `rd_valid` is 0.
- R2: An accepted command with `cmd_op` = 0 (select) drives `spi_cs_n` to 0 on the following clock edge. It stays 0 across any number of byte transfers until a deselect is accepted.
- R3: An accepted command with `cmd_op` = 1 (deselect) drives `spi_cs_n` to 1 on the following clock edge.
- R4: An accepted command with `cmd_op` = 2 (send) shifts `cmd_wdata` out on `spi_mosi`, MSB first, with exactly 8 rising `spi_sclk` edges. `spi_mosi` changes only while `spi_sclk` is low.
- R5: An accepted command with `cmd_op` = 3 (fetch) samples `spi_miso` on each of 8 rising `spi_sclk` edges, MSB first. When busy clears, the byte appears on `rd_data` and `rd_valid` pulses for one cycle.
- R6: During a fetch, `spi_mosi` stays 0.
- R7: `cmd_busy` rises on the edge that accepts a send or fetch and stays high for exactly 16*(`clk_div`+1) cycles.
- R8: A command is accepted only when `cmd_valid` is 1 and `cmd_busy` is 0. A command held on `cmd_valid` during a transfer has no effect until busy clears, and then takes effect.
- R9: `spi_sclk` is 0 whenever `cmd_busy` is 0, including whenever chip select is deasserted.
- R10: A send leaves `rd_data` unchanged and produces no `rd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Half-period of serial clock minus one, in system cycles |
| cmd_valid | input | 1 | Command request from the core |
| cmd_op | input | 2 | 0 select, 1 deselect, 2 send byte, 3 fetch byte |
| cmd_wdata | input | 8 | Byte to send |
| cmd_busy | output | 1 | Byte transfer in progress; commands are held off |
| rd_data | output | 8 | Last fetched byte |
| rd_valid | output | 1 | One-cycle pulse when a fetched byte lands |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Flash chip select, active low |

## Verification
The bench builds the block with its default `DIV_W` of 4 and steers the divider at run time to 0, 1 and 3. Each setting gives a different half-period, so the busy-length rule and mode-0 data placement are measured both at full rate and with multi-cycle serial-clock phases. The slowest setting also gives a long enough window to hold a deselect request against an active transfer and to see that chip select stays put.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    typedef enum logic [1:0] {
        OP_SELECT   = 2'd0,
        OP_DESELECT = 2'd1,
        OP_SEND     = 2'd2,
        OP_FETCH    = 2'd3
    } op_e;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == div);
        if (!run || tick) st_d.cnt = '0;
        else              st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(div)) |-> (st_q.cnt <= div));
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            fetch,
    input  logic [BITS-1:0] tx_byte,
    input  logic            tick,
    input  logic            miso,
    output logic            busy,
    output logic            sclk,
    output logic            mosi,
    output logic [BITS-1:0] rx_byte,
    output logic            rx_valid
);
    localparam int CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

    typedef struct packed {
        logic            busy;
        logic            sclk;
        logic            fetch;
        logic [BITS-1:0] tx;
        logic [BITS-1:0] rx;
        logic [CNT_W-1:0] cnt;
        logic [BITS-1:0] rdata;
        logic            rvalid;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        if (start && !st_q.busy) begin
            st_d.busy  = 1'b1;
            st_d.sclk  = 1'b0;
            st_d.fetch = fetch;
            st_d.tx    = fetch ? '0 : tx_byte;
            st_d.cnt   = '0;
        end else if (st_q.busy && tick) begin
            if (!st_q.sclk) begin
                st_d.sclk = 1'b1;
                st_d.rx   = {st_q.rx[BITS-2:0], miso};
            end else begin
                st_d.sclk = 1'b0;
                if (st_q.cnt == LAST) begin
                    st_d.busy = 1'b0;
                    st_d.tx   = '0;
                    if (st_q.fetch) begin
                        st_d.rdata  = st_q.rx;
                        st_d.rvalid = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    st_d.tx  = {st_q.tx[BITS-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign sclk     = st_q.sclk;
    assign mosi     = st_q.tx[BITS-1];
    assign rx_byte  = st_q.rdata;
    assign rx_valid = st_q.rvalid;

    // R9
    sclk_rests_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> !st_q.sclk);
    // R4
    mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sclk && $past(st_q.sclk)) |-> $stable(mosi));
    // R6
    fetch_mosi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.fetch) |-> !mosi);
    // R5
    rvalid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rvalid |-> (!st_q.busy && $past(st_q.busy)));
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic go_low,
    input  logic go_high,
    output logic cs_n
);
    typedef struct packed {
        logic cs_n;
    } cs_st_t;

    cs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (go_low)       st_d.cs_n = 1'b0;
        else if (go_high) st_d.cs_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cs_n: 1'b1};
        else        st_q <= st_d;
    end

    assign cs_n = st_q.cs_n;

    // R2
    cs_only_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.cs_n) |-> $past(go_low || go_high));
endmodule

// File: rtl/spi_cmd_port.sv
module spi_cmd_port
    import spi_cmd_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [7:0]       cmd_wdata,
    output logic             cmd_busy,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n
);
    logic xfer_busy, accept, tick, is_xfer;
    op_e  op;

    assign op      = op_e'(cmd_op);
    assign accept  = cmd_valid && !xfer_busy;
    assign is_xfer = (op == OP_SEND) || (op == OP_FETCH);

    spi_cs_ctrl u_cs (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_low  (accept && (op == OP_SELECT)),
        .go_high (accept && (op == OP_DESELECT)),
        .cs_n    (spi_cs_n)
    );

    spi_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (xfer_busy),
        .div   (clk_div),
        .tick  (tick)
    );

    spi_byte_shifter #(.BITS(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept && is_xfer),
        .fetch    (op == OP_FETCH),
        .tx_byte  (cmd_wdata),
        .tick     (tick),
        .miso     (spi_miso),
        .busy     (xfer_busy),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .rx_byte  (rd_data),
        .rx_valid (rd_valid)
    );

    assign cmd_busy = xfer_busy;

    // R8
    cs_frozen_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_cs_n) |-> !$past(xfer_busy));
    // R10
    send_keeps_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rd_data)) |-> rd_valid);
endmodule

// File: tb/spi_cmd_port_bench.sv
module spi_cmd_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 4;

    logic clk = 0, rst_n = 0;
    logic [DIV_W-1:0] clk_div = '0;
    logic cmd_valid = 0;
    logic [1:0] cmd_op = '0;
    logic [7:0] cmd_wdata = '0;
    logic cmd_busy, rd_valid, spi_sclk, spi_mosi, spi_cs_n;
    logic [7:0] rd_data;
    logic [7:0] miso_sr = '0;
    logic spi_miso;

    int n_vec = 0, n_bad = 0;
    logic [7:0] mon_byte = '0;
    int mon_edges = 0, mosi_glitch = 0, mosi_hi = 0, rv_count = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_port #(.DIV_W(DIV_W)) u_spi_cmd_port (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy),
        .rd_data(rd_data), .rd_valid(rd_valid), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    assign spi_miso = miso_sr[7];

    always @(posedge spi_sclk) begin
        mon_byte = {mon_byte[6:0], spi_mosi};
        mon_edges++;
    end
    always @(negedge spi_sclk) miso_sr = {miso_sr[6:0], 1'b0};
    always @(spi_mosi) if (spi_sclk) mosi_glitch++;
    always @(negedge clk) if (cmd_busy && spi_mosi) mosi_hi++;
    always @(posedge clk) if (rd_valid) rv_count++;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(logic [1:0] op, logic [7:0] data);
        @(negedge clk);
        while (cmd_busy) @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_wdata = data;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (cmd_busy) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 cs_n", spi_cs_n, 1);
        chk("R1 sclk", spi_sclk, 0);
        chk("R1 mosi", spi_mosi, 0);
        chk("R1 busy", cmd_busy, 0);
        chk("R1 rd_valid", rd_valid, 0);
    endtask

    task automatic t_select();
        issue(2'd0, 8'h00);
        chk("R2 cs_n low after select", spi_cs_n, 0);
    endtask

    task automatic t_send(logic [7:0] data, int div);
        int cyc;
        logic [7:0] old_rd;
        clk_div = DIV_W'(div);
        old_rd = rd_data;
        mon_edges = 0; mosi_glitch = 0; rv_count = 0;
        issue(2'd2, data);
        chk("R7 busy up after send", cmd_busy, 1);
        wait_idle(cyc);
        chk("R7 send busy length", cyc, 16 * (div + 1));
        chk("R4 send byte on mosi", mon_byte, data);
        chk("R4 eight rising edges", mon_edges, 8);
        chk("R4 mosi only moves while sclk low", mosi_glitch, 0);
        chk("R10 no rd_valid on send", rv_count, 0);
        chk("R10 rd_data kept on send", rd_data, old_rd);
        chk("R9 sclk low when idle", spi_sclk, 0);
        chk("R2 cs_n held across byte", spi_cs_n, 0);
    endtask

    task automatic t_fetch(logic [7:0] pat, int div);
        int cyc;
        clk_div = DIV_W'(div);
        miso_sr = pat;
        mon_edges = 0; mosi_hi = 0;
        issue(2'd3, 8'hFF);
        wait_idle(cyc);
        chk("R7 fetch busy length", cyc, 16 * (div + 1));
        chk("R5 rd_valid pulse", rd_valid, 1);
        chk("R5 fetched byte", rd_data, pat);
        chk("R5 eight rising edges", mon_edges, 8);
        chk("R6 mosi low in fetch", mosi_hi, 0);
        @(negedge clk);
        chk("R5 rd_valid single cycle", rd_valid, 0);
        chk("R2 cs_n held after fetch", spi_cs_n, 0);
    endtask

    task automatic t_holdoff();
        int early = 0;
        clk_div = DIV_W'(3);
        issue(2'd2, 8'hA5);
        cmd_valid = 1; cmd_op = 2'd1; cmd_wdata = 8'h00;
        while (cmd_busy) begin
            if (spi_cs_n !== 1'b0) early++;
            @(negedge clk);
        end
        chk("R8 deselect held off while busy", early, 0);
        chk("R8 cs_n before acceptance", spi_cs_n, 0);
        @(negedge clk);
        cmd_valid = 0;
        chk("R8 held deselect applied after busy", spi_cs_n, 1);
        chk("R3 cs_n high after deselect", spi_cs_n, 1);
        chk("R9 sclk low with cs high", spi_sclk, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_select();
        t_send(8'hA5, 0);
        t_send(8'h3C, 1);
        t_fetch(8'hC3, 0);
        t_send(8'h01, 3);
        t_fetch(8'h5A, 3);
        t_fetch(8'h81, 1);
        t_holdoff();
        t_select();
        t_fetch(8'hE7, 0);
        issue(2'd1, 8'h00);
        chk("R3 cs_n high after second deselect", spi_cs_n, 1);
        finish_run();
    end
endmodule